// File: doc/BRIEF.md
# Trace Port Control Register Block

This block holds the software-visible control and status registers of a debug trace port. A host reaches it over a simple 32-bit register bus with one request per cycle. Every read returns its data one clock later, marked by a valid pulse. The registers are:

- a fixed revision word
- a configuration word whose write can also reset the whole block
- a system status word that always reads zero
- a pending-interrupt word with write-one-to-clear bits
- an interrupt enable mask
- two byte-wide settings, one for the trace clock and one for the serial link

Hardware events arrive on an input vector and set pending bits. A single level interrupt output is high while any pending bit is also enabled. Any access to an offset that decodes to nothing, and any write to a read-only word, produces a one-cycle error pulse. Such accesses change no state.

Top module: `trace_ctl_regs`

## Requirements
- R1: Offset 0x00 always reads 0x0000_0010; a write there changes nothing and raises the error pulse.
- R2: A write to offset 0x10 stores the low byte of the data ANDed with 0xFE, and upper bits read as zero.
- R3: A write to offset 0x10 with data bit 1 set clears pending, enable, clock and serial registers in that same cycle. Events arriving in that cycle are dropped. The configuration then holds the masked value from R2.
- R4: Offset 0x14 always reads zero without an error; a write there raises the error pulse.
- R5: A write to offset 0x18 clears each pending bit where the data has a one and leaves bits with a zero unchanged.
- R6: A one on bit i of hw_event sets pending bit i at the next edge. When a clear and a set meet on the same bit in the same cycle, the set wins.
- R7: Offset 0x1C keeps only data bits 15:0 as the enable mask.
- R8: irq is high exactly when pending AND enable is nonzero, following every register update with no extra cycle.
- R9: Offset 0x2C (clock setting) and offset 0x30 (serial setting) each keep only data bits 7:0.
- R10: Offsets 0x24, 0x28 and every unlisted offset read as zero, ignore writes and raise the error pulse.
- R11: rd_valid pulses for one cycle in the cycle after each read request, with rd_data valid alongside; writes produce no rd_valid.
- R12: After hardware reset every stored register is zero and irq is low.
- R13: bad_access is high for exactly the cycle after each invalid access and low otherwise; reads of read-only offsets do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| hw_event | input | IRQ_W | Event bits that set pending status |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| bad_access | output | 1 | One-cycle invalid access pulse |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a collision on one pending bit. In that cycle a write-one-to-clear, a hardware event set and sometimes a soft reset all act on the same bit. The bench reaches it by holding hw_event during the exact cycle in which its bus write task presents the clear or configuration write. It then reads the pending word back to see which of the three won. A further check first arms irq through the enable mask, then drops it through a soft reset, confirming that the line follows the cleared registers without delay.

// File: rtl/trace_ctl_pkg.sv
package trace_ctl_pkg;

  localparam logic [7:0]  OFF_REV  = 8'h00;
  localparam logic [7:0]  OFF_CFG  = 8'h10;
  localparam logic [7:0]  OFF_SYS  = 8'h14;
  localparam logic [7:0]  OFF_IST  = 8'h18;
  localparam logic [7:0]  OFF_IEN  = 8'h1C;
  localparam logic [7:0]  OFF_CLK  = 8'h2C;
  localparam logic [7:0]  OFF_SER  = 8'h30;

  localparam logic [31:0] REV_VALUE = 32'h0000_0010;
  localparam int          SRST_BIT  = 1;
  localparam logic [7:0]  CFG_KEEP  = 8'hFE;

  typedef enum logic [2:0] {
    SEL_REV,
    SEL_CFG,
    SEL_SYS,
    SEL_IST,
    SEL_IEN,
    SEL_CLK,
    SEL_SER,
    SEL_NONE
  } reg_sel_e;

  function automatic logic [7:0] cfg_keep(input logic [7:0] w);
    return w & CFG_KEEP;
  endfunction

  function automatic logic pend_next(input logic cur, input logic clr, input logic set);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic logic irq_any(input logic [31:0] st, input logic [31:0] en);
    return |(st & en);
  endfunction

  function automatic logic sel_read_only(input reg_sel_e s);
    return (s == SEL_REV) || (s == SEL_SYS);
  endfunction

endpackage

// File: rtl/trc_addr_dec.sv
module trc_addr_dec
  import trace_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output reg_sel_e          sel_o,
  output logic              bad_o,
  output logic              wr_ok_o,
  output logic              rd_o
);

  always_comb begin
    sel_o = SEL_NONE;
    if      (req_addr == ADDR_W'(OFF_REV)) sel_o = SEL_REV;
    else if (req_addr == ADDR_W'(OFF_CFG)) sel_o = SEL_CFG;
    else if (req_addr == ADDR_W'(OFF_SYS)) sel_o = SEL_SYS;
    else if (req_addr == ADDR_W'(OFF_IST)) sel_o = SEL_IST;
    else if (req_addr == ADDR_W'(OFF_IEN)) sel_o = SEL_IEN;
    else if (req_addr == ADDR_W'(OFF_CLK)) sel_o = SEL_CLK;
    else if (req_addr == ADDR_W'(OFF_SER)) sel_o = SEL_SER;
  end

  always_comb begin
    bad_o   = req_valid && ((sel_o == SEL_NONE) || (req_write && sel_read_only(sel_o)));
    wr_ok_o = req_valid && req_write && !bad_o;
    rd_o    = req_valid && !req_write;
  end

endmodule

// File: rtl/trc_reg_file.sv
module trc_reg_file
  import trace_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 16,
  parameter int CFG_W  = 8,
  parameter int CLK_W  = 8,
  parameter int SER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IRQ_W-1:0]  hw_event,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [IRQ_W-1:0]  ist_q,
  output logic [IRQ_W-1:0]  ien_q,
  output logic [CLK_W-1:0]  clk_q,
  output logic [SER_W-1:0]  ser_q,
  output logic [IRQ_W-1:0]  ist_clr_o,
  output logic              soft_rst_o
);

  logic wr_cfg, wr_ist, wr_ien, wr_clk, wr_ser;

  always_comb begin
    wr_cfg     = wr_ok && (sel == SEL_CFG);
    wr_ist     = wr_ok && (sel == SEL_IST);
    wr_ien     = wr_ok && (sel == SEL_IEN);
    wr_clk     = wr_ok && (sel == SEL_CLK);
    wr_ser     = wr_ok && (sel == SEL_SER);
    soft_rst_o = wr_cfg && wdata[SRST_BIT];
    ist_clr_o  = wr_ist ? wdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= CFG_W'(cfg_keep(wdata[7:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ien_q <= '0;
    else if (soft_rst_o) ien_q <= '0;
    else if (wr_ien)     ien_q <= wdata[IRQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          clk_q <= '0;
    else if (soft_rst_o) clk_q <= '0;
    else if (wr_clk)     clk_q <= wdata[CLK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ser_q <= '0;
    else if (soft_rst_o) ser_q <= '0;
    else if (wr_ser)     ser_q <= wdata[SER_W-1:0];
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ist_q[i] <= 1'b0;
      else if (soft_rst_o) ist_q[i] <= 1'b0;
      else                 ist_q[i] <= pend_next(ist_q[i], ist_clr_o[i], hw_event[i]);
    end
  end

endmodule

// File: rtl/trc_irq_out.sv
module trc_irq_out
  import trace_ctl_pkg::*;
#(
  parameter int IRQ_W = 16
) (
  input  logic [IRQ_W-1:0] ist_q,
  input  logic [IRQ_W-1:0] ien_q,
  output logic             irq_o
);

  always_comb irq_o = irq_any(32'(ist_q), 32'(ien_q));

endmodule

// File: rtl/trc_rd_port.sv
module trc_rd_port
  import trace_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 16,
  parameter int CFG_W  = 8,
  parameter int CLK_W  = 8,
  parameter int SER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              bad_req,
  input  reg_sel_e          sel,
  input  logic [CFG_W-1:0]  cfg_q,
  input  logic [IRQ_W-1:0]  ist_q,
  input  logic [IRQ_W-1:0]  ien_q,
  input  logic [CLK_W-1:0]  clk_q,
  input  logic [SER_W-1:0]  ser_q,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad_access
);

  logic [DATA_W-1:0] mux_d;

  always_comb begin
    case (sel)
      SEL_REV: mux_d = DATA_W'(REV_VALUE);
      SEL_CFG: mux_d = DATA_W'(cfg_q);
      SEL_IST: mux_d = DATA_W'(ist_q);
      SEL_IEN: mux_d = DATA_W'(ien_q);
      SEL_CLK: mux_d = DATA_W'(clk_q);
      SEL_SER: mux_d = DATA_W'(ser_q);
      default: mux_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      bad_access <= 1'b0;
    end else begin
      rd_valid   <= rd_req;
      rd_data    <= rd_req ? mux_d : '0;
      bad_access <= bad_req;
    end
  end

endmodule

// File: rtl/trace_ctl_regs.sv
module trace_ctl_regs
  import trace_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 16,
  parameter int CFG_W  = 8,
  parameter int CLK_W  = 8,
  parameter int SER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [IRQ_W-1:0]  hw_event,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad_access,
  output logic              irq
);

  reg_sel_e         sel;
  logic             dec_bad, wr_ok, rd_req, soft_rst;
  logic [CFG_W-1:0] cfg_q;
  logic [IRQ_W-1:0] ist_q, ien_q, ist_clr;
  logic [CLK_W-1:0] clk_q;
  logic [SER_W-1:0] ser_q;

  trc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .sel_o     (sel),
    .bad_o     (dec_bad),
    .wr_ok_o   (wr_ok),
    .rd_o      (rd_req)
  );

  trc_reg_file #(
    .DATA_W(DATA_W), .IRQ_W(IRQ_W), .CFG_W(CFG_W), .CLK_W(CLK_W), .SER_W(SER_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ok      (wr_ok),
    .sel        (sel),
    .wdata      (req_wdata),
    .hw_event   (hw_event),
    .cfg_q      (cfg_q),
    .ist_q      (ist_q),
    .ien_q      (ien_q),
    .clk_q      (clk_q),
    .ser_q      (ser_q),
    .ist_clr_o  (ist_clr),
    .soft_rst_o (soft_rst)
  );

  trc_irq_out #(.IRQ_W(IRQ_W)) u_irq (
    .ist_q (ist_q),
    .ien_q (ien_q),
    .irq_o (irq)
  );

  trc_rd_port #(
    .DATA_W(DATA_W), .IRQ_W(IRQ_W), .CFG_W(CFG_W), .CLK_W(CLK_W), .SER_W(SER_W)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .bad_req    (dec_bad),
    .sel        (sel),
    .cfg_q      (cfg_q),
    .ist_q      (ist_q),
    .ien_q      (ien_q),
    .clk_q      (clk_q),
    .ser_q      (ser_q),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .bad_access (bad_access)
  );

endmodule

// File: rtl/trace_ctl_chk.sv
module trace_ctl_chk #(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 16,
  parameter int CLK_W  = 8,
  parameter int SER_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [IRQ_W-1:0]  hw_event,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              bad_access,
  input logic              irq,
  input logic [IRQ_W-1:0]  ist_q,
  input logic [IRQ_W-1:0]  ien_q,
  input logic [CLK_W-1:0]  clk_q,
  input logic [SER_W-1:0]  ser_q,
  input logic [IRQ_W-1:0]  ist_clr,
  input logic              soft_rst,
  input logic              dec_bad
);

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(ist_q & ien_q)));

  // R6
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hw_event) && !soft_rst) |=> ((ist_q & $past(hw_event)) == $past(hw_event)));

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ist_clr) && !soft_rst) |=> ((ist_q & $past(ist_clr) & ~$past(hw_event)) == '0));

  // R3
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ist_q == '0 && ien_q == '0 && clk_q == '0 && ser_q == '0));

  // R11
  rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  // R13
  bad_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(req_valid));

  // R10
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && dec_bad) |=> (rd_valid && rd_data == '0 && bad_access));

endmodule

bind trace_ctl_regs trace_ctl_chk #(
  .DATA_W(DATA_W), .IRQ_W(IRQ_W), .CLK_W(CLK_W), .SER_W(SER_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .hw_event   (hw_event),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .bad_access (bad_access),
  .irq        (irq),
  .ist_q      (ist_q),
  .ien_q      (ien_q),
  .clk_q      (clk_q),
  .ser_q      (ser_q),
  .ist_clr    (ist_clr),
  .soft_rst   (soft_rst),
  .dec_bad    (dec_bad)
);

// File: tb/test_trace_ctl_regs.sv
module test_trace_ctl_regs;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [15:0] hw_event = '0;
  logic        rd_valid, bad_access, irq;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_ctl_regs i_trace_ctl_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .hw_event(hw_event),
    .rd_valid(rd_valid), .rd_data(rd_data), .bad_access(bad_access), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Restated rules used for expected values
  function automatic logic [31:0] exp_cfg(input logic [31:0] w);
    return {24'h0, w[7:1], 1'b0};
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [15:0] ev,
                           output logic bad, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; hw_event = ev;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; hw_event = '0;
    bad = bad_access; vld = rd_valid;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d,
                          output logic bad, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data; bad = bad_access; vld = rd_valid;
  endtask

  task automatic rd_expect(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d; logic b, v;
    bus_read(a, d, b, v);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R12 irq after reset", 32'(irq), 32'd0);
    rd_expect("R12 cfg", 8'h10, 32'h0);
    rd_expect("R12 pending", 8'h18, 32'h0);
    rd_expect("R12 enable", 8'h1C, 32'h0);
    rd_expect("R12 clock", 8'h2C, 32'h0);
    rd_expect("R12 serial", 8'h30, 32'h0);
  endtask

  task automatic t_revision;
    logic [31:0] d; logic b, v;
    bus_read(8'h00, d, b, v);
    check("R1 revision value", d, 32'h10);
    check("R13 read-only read not flagged", 32'(b), 32'd0);
    check("R11 rd_valid after read", 32'(v), 32'd1);
    bus_write(8'h00, 32'hFFFF_FFFF, '0, b, v);
    check("R1 revision write flagged", 32'(b), 32'd1);
    check("R11 no rd_valid on write", 32'(v), 32'd0);
    rd_expect("R1 revision unchanged", 8'h00, 32'h10);
  endtask

  task automatic t_config;
    logic b, v;
    bus_write(8'h10, 32'hABCD_00F5, '0, b, v);
    check("R2 cfg write not flagged", 32'(b), 32'd0);
    rd_expect("R2 cfg masked", 8'h10, exp_cfg(32'hABCD_00F5));
  endtask

  task automatic t_sysstat;
    logic [31:0] d; logic b, v;
    bus_read(8'h14, d, b, v);
    check("R4 status reads zero", d, 32'h0);
    check("R4 status read not flagged", 32'(b), 32'd0);
    bus_write(8'h14, 32'h1234_5678, '0, b, v);
    check("R4 status write flagged", 32'(b), 32'd1);
    rd_expect("R4 status still zero", 8'h14, 32'h0);
  endtask

  task automatic t_masks;
    logic b, v;
    bus_write(8'h1C, 32'hDEAD_BEEF, '0, b, v);
    rd_expect("R7 enable low 16 bits", 8'h1C, 32'h0000_BEEF);
    bus_write(8'h2C, 32'h1234_56A7, '0, b, v);
    rd_expect("R9 clock low byte", 8'h2C, 32'h0000_00A7);
    bus_write(8'h30, 32'hFFFF_FF3C, '0, b, v);
    rd_expect("R9 serial low byte", 8'h30, 32'h0000_003C);
  endtask

  task automatic t_pending;
    logic b, v;
    bus_write(8'h1C, 32'h0, '0, b, v);
    @(negedge clk); hw_event = 16'h0005;
    @(negedge clk); hw_event = '0;
    check("R8 irq low with mask zero", 32'(irq), 32'd0);
    rd_expect("R6 events set pending", 8'h18, 32'h0005);
    bus_write(8'h1C, 32'h0000_0004, '0, b, v);
    check("R8 irq rises with enable", 32'(irq), 32'd1);
    bus_write(8'h18, 32'h0000_0001, '0, b, v);
    rd_expect("R5 clear one bit only", 8'h18, 32'h0004);
    check("R8 irq held by enabled bit", 32'(irq), 32'd1);
    bus_write(8'h18, 32'h0000_0004, '0, b, v);
    check("R8 irq falls after clear", 32'(irq), 32'd0);
    rd_expect("R5 pending empty", 8'h18, 32'h0);
    bus_write(8'h18, 32'h0000_0008, 16'h0008, b, v);
    rd_expect("R6 set wins over clear", 8'h18, 32'h0008);
  endtask

  task automatic t_soft_reset;
    logic b, v;
    bus_write(8'h1C, 32'h0000_FFFF, '0, b, v);
    bus_write(8'h2C, 32'h0000_005A, '0, b, v);
    bus_write(8'h30, 32'h0000_0033, '0, b, v);
    check("R8 irq armed before soft reset", 32'(irq), 32'd1);
    bus_write(8'h10, 32'h0000_000F, 16'h0001, b, v);
    check("R3 irq low after soft reset", 32'(irq), 32'd0);
    rd_expect("R3 cfg keeps masked value", 8'h10, exp_cfg(32'h0000_000F));
    rd_expect("R3 pending cleared, event dropped", 8'h18, 32'h0);
    rd_expect("R3 enable cleared", 8'h1C, 32'h0);
    rd_expect("R3 clock cleared", 8'h2C, 32'h0);
    rd_expect("R3 serial cleared", 8'h30, 32'h0);
  endtask

  task automatic t_invalid;
    logic [31:0] d; logic b, v;
    bus_write(8'h1C, 32'h0000_00F0, '0, b, v);
    bus_read(8'h24, d, b, v);
    check("R10 read 0x24 zero", d, 32'h0);
    check("R10 read 0x24 flagged", 32'(b), 32'd1);
    check("R11 rd_valid on bad read", 32'(v), 32'd1);
    bus_write(8'h28, 32'hFFFF_FFFF, '0, b, v);
    check("R10 write 0x28 flagged", 32'(b), 32'd1);
    bus_write(8'h1D, 32'hFFFF_FFFF, '0, b, v);
    check("R10 unlisted write flagged", 32'(b), 32'd1);
    @(negedge clk);
    check("R13 pulse lasts one cycle", 32'(bad_access), 32'd0);
    rd_expect("R10 enable untouched", 8'h1C, 32'h0000_00F0);
    rd_expect("R10 cfg untouched", 8'h10, exp_cfg(32'h0000_000F));
    bus_read(8'h3C, d, b, v);
    check("R10 unlisted read zero", d, 32'h0);
    check("R10 unlisted read flagged", 32'(b), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_revision();
    t_config();
    t_sysstat();
    t_masks();
    t_pending();
    t_soft_reset();
    t_invalid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule